// File: doc/BRIEF.md
# Successive-Approximation ADC Host Sequencer

This block sits on the host side of a 14-bit successive-approximation converter. The converter has an internal conversion clock, a chip-select line, a read/convert line, a high-byte-enable line, an active-low end-of-conversion output and an 8-bit parallel data bus. A single start request, together with a power-mode choice, makes the sequencer run one complete conversion. It pulls chip-select low twice to open and then close a timed acquisition window. It then waits for end-of-conversion, reads the result as a low byte and a high byte, and returns a 14-bit word with a one-cycle valid strobe.

The level on the read/convert line at the second chip-select edge sets the converter's state after the conversion. Low keeps the reference powered (standby). High powers the reference down (shutdown). The sequencer keeps track of which state the converter was left in. When the converter may be powered down, it first waits out the reference wake-up time. It then runs one dummy conversion and discards its data before it runs the conversion that was requested. After reset the converter is assumed to be powered down. All timing limits are parameters given in clock cycles. Floors derived from the clock rate are checked when the design is elaborated.

Top module: `sar_host_seq`

## Requirements
- R1: During and after reset, chip-select is high, busy, valid and timeout are low, and the sleep flag is high.
- R2: A start request while idle raises busy in the next cycle. A start request while busy is ignored: it neither changes the power mode chosen for the running request nor adds a conversion.
- R3: Every chip-select falling edge that opens acquisition has read/convert low. The next falling edge follows exactly ACQ_CYC cycles later. ACQ_CYC may not be below the cycle count of 1.1 us. Chip-select never falls with read/convert high except to read data.
- R4: At the edge that closes acquisition, read/convert equals the requested mode (1 = shutdown, 0 = standby) for a reported conversion, and 0 for a dummy conversion.
- R5: If end-of-conversion does not fall within CONV_TMO_CYC cycles of the closing edge, timeout pulses for one cycle with no valid and busy drops. The converter is then treated as powered down.
- R6: Data is read with chip-select low and read/convert high, low byte first (high-byte-enable 0), then high byte (high-byte-enable 1). The result is {high_byte[5:0], low_byte[7:0]}, and high_byte[7:6] has no effect.
- R7: After a reported result, the sleep flag equals the mode used for that conversion.
- R8: If the sleep flag is set at the start, at least WAKE_CYC cycles pass before the first chip-select falling edge, and exactly two conversions run, of which only the second is reported. Otherwise one conversion runs with no wake-up wait.
- R9: Valid is a single-cycle pulse that arrives with busy low, once per reported conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, sampled while idle |
| shutdown_i | input | 1 | Mode after this conversion: 1 power down, 0 standby |
| busy_o | output | 1 | Request in progress |
| asleep_o | output | 1 | Converter assumed powered down |
| data_o | output | 14 | Last reported conversion result |
| valid_o | output | 1 | One-cycle strobe for data_o |
| timeout_o | output | 1 | One-cycle strobe: end-of-conversion missing |
| adc_cs_n_o | output | 1 | Converter chip-select, active low |
| adc_rc_o | output | 1 | Converter read/convert select |
| adc_hben_o | output | 1 | Converter high-byte enable |
| adc_eoc_n_i | input | 1 | Converter end-of-conversion, active low, asynchronous |
| adc_bus_i | input | 8 | Converter parallel data bus |

## Verification
The assertions assume that end-of-conversion rises again only when a new acquisition starts, and that the data bus is stable while chip-select is low through a byte's settle delay. The bench's converter model keeps end-of-conversion low from the end of a conversion until the next acquisition-opening edge. It drives the bus combinationally from high-byte-enable and a sample held for the whole read. Random requests put a timeout only on requests that start from standby, so a missing end-of-conversion always falls on a conversion that is reported and never on a dummy one.

// File: rtl/sar_host_seq_pkg.sv
package sar_host_seq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WAKE,
      ST_ARM,
      ST_EDGE1,
      ST_ACQ,
      ST_EDGE2,
      ST_CONV,
      ST_RDLO,
      ST_RDHI,
      ST_DONE
   } seq_state_t;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sar_host_seq_timer.sv
module sar_host_seq_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic         zero_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= val_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sar_host_seq_sync.sv
module sar_host_seq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '1;
            else        sh_q <= {sh_q[STAGES-2+((STAGES==1)?1:0):0], d_i};
         end
         assign q_o = sh_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sar_host_seq_pack.sv
module sar_host_seq_pack #(
   parameter int BUS_W  = 8,
   parameter int DATA_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_lo_i,
   input  logic              cap_hi_i,
   input  logic [BUS_W-1:0]  bus_i,
   output logic [DATA_W-1:0] word_o
);
   localparam int HI_W = DATA_W - BUS_W;

   logic [BUS_W-1:0] lo_q;
   logic [HI_W-1:0]  hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         if (cap_lo_i) lo_q <= bus_i;
         if (cap_hi_i) hi_q <= bus_i[HI_W-1:0];
      end
   end

   assign word_o = {hi_q, lo_q};
endmodule

// File: rtl/sar_host_seq.sv
module sar_host_seq
   import sar_host_seq_pkg::*;
#(
   parameter int CLK_KHZ      = 125000,
   parameter int ACQ_CYC      = 138,
   parameter int CONV_TMO_CYC = 640,
   parameter int WAKE_CYC     = 1250000,
   parameter int SETTLE_CYC   = 2,
   parameter int SYNC_STAGES  = 2,
   parameter int BUS_W        = 8,
   parameter int DATA_W       = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              shutdown_i,
   output logic              busy_o,
   output logic              asleep_o,
   output logic [DATA_W-1:0] data_o,
   output logic              valid_o,
   output logic              timeout_o,
   output logic              adc_cs_n_o,
   output logic              adc_rc_o,
   output logic              adc_hben_o,
   input  logic              adc_eoc_n_i,
   input  logic [BUS_W-1:0]  adc_bus_i
);
   localparam int ACQ_FLOOR  = (1100 * CLK_KHZ + 999999) / 1000000;
   localparam int CONV_FLOOR = (4700 * CLK_KHZ + 999999) / 1000000;
   localparam int WAKE_FLOOR = 10 * CLK_KHZ;
   localparam int MAXV = max_of(max_of(WAKE_CYC, CONV_TMO_CYC), max_of(ACQ_CYC, SETTLE_CYC));
   localparam int CNT_W = $clog2(MAXV + 1);

   generate
      if (ACQ_CYC < ACQ_FLOOR || ACQ_CYC < 2) begin : g_bad_acq
         $error("acquisition window below 1.1 us floor");
      end
      if (CONV_TMO_CYC <= CONV_FLOOR) begin : g_bad_tmo
         $error("conversion timeout not above 4.7 us");
      end
      if (WAKE_CYC < WAKE_FLOOR) begin : g_bad_wake
         $error("wake-up wait below 10 ms floor");
      end
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("bus settle delay must be at least one cycle");
      end
      if (DATA_W <= BUS_W || DATA_W - BUS_W > BUS_W) begin : g_bad_width
         $error("result must span exactly two bus reads");
      end
   endgenerate

   seq_state_t        state_q, state_d;
   logic              mode_q, dummy_q, asleep_q, valid_q, tmo_q;
   logic [DATA_W-1:0] data_q, word;
   logic              eoc_s, eoc_prev_q, eoc_fall;
   logic              tmr_load, tmr_zero, cap_lo, cap_hi;
   logic [CNT_W-1:0]  tmr_val;

   sar_host_seq_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d_i(adc_eoc_n_i), .q_o(eoc_s));

   sar_host_seq_timer #(.W(CNT_W)) i_timer (
      .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero));

   sar_host_seq_pack #(.BUS_W(BUS_W), .DATA_W(DATA_W)) i_pack (
      .clk(clk), .rst_n(rst_n), .cap_lo_i(cap_lo), .cap_hi_i(cap_hi),
      .bus_i(adc_bus_i), .word_o(word));

   assign eoc_fall = eoc_prev_q & ~eoc_s;

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      cap_lo   = 1'b0;
      cap_hi   = 1'b0;
      unique case (state_q)
         ST_IDLE: if (start_i) begin
            if (asleep_q) begin
               state_d  = ST_WAKE;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(WAKE_CYC - 1);
            end else begin
               state_d  = ST_ARM;
            end
         end
         ST_WAKE:  if (tmr_zero) state_d = ST_ARM;
         ST_ARM:   state_d = ST_EDGE1;
         ST_EDGE1: begin
            state_d  = ST_ACQ;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(ACQ_CYC - 2);
         end
         ST_ACQ:   if (tmr_zero) state_d = ST_EDGE2;
         ST_EDGE2: begin
            state_d  = ST_CONV;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(CONV_TMO_CYC - 1);
         end
         ST_CONV: begin
            if (eoc_fall) begin
               state_d  = ST_RDLO;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(SETTLE_CYC - 1);
            end else if (tmr_zero) begin
               state_d = ST_IDLE;
            end
         end
         ST_RDLO: if (tmr_zero) begin
            state_d  = ST_RDHI;
            cap_lo   = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(SETTLE_CYC - 1);
         end
         ST_RDHI: if (tmr_zero) begin
            state_d = ST_DONE;
            cap_hi  = 1'b1;
         end
         ST_DONE:  state_d = dummy_q ? ST_ARM : ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         mode_q     <= 1'b0;
         dummy_q    <= 1'b0;
         asleep_q   <= 1'b1;
         valid_q    <= 1'b0;
         tmo_q      <= 1'b0;
         data_q     <= '0;
         eoc_prev_q <= 1'b1;
      end else begin
         state_q    <= state_d;
         eoc_prev_q <= eoc_s;
         valid_q    <= 1'b0;
         tmo_q      <= 1'b0;
         if (state_q == ST_IDLE && start_i) begin
            mode_q  <= shutdown_i;
            dummy_q <= asleep_q;
            if (asleep_q) asleep_q <= 1'b0;
         end
         if (state_q == ST_CONV && !eoc_fall && tmr_zero) begin
            tmo_q    <= 1'b1;
            asleep_q <= 1'b1;
         end
         if (state_q == ST_DONE) begin
            if (dummy_q) begin
               dummy_q <= 1'b0;
            end else begin
               valid_q  <= 1'b1;
               data_q   <= word;
               asleep_q <= mode_q;
            end
         end
      end
   end

   assign busy_o     = (state_q != ST_IDLE);
   assign asleep_o   = asleep_q;
   assign data_o     = data_q;
   assign valid_o    = valid_q;
   assign timeout_o  = tmo_q;
   assign adc_cs_n_o = !(state_q == ST_EDGE1 || state_q == ST_EDGE2 ||
                         state_q == ST_RDLO  || state_q == ST_RDHI);
   assign adc_rc_o   = (state_q == ST_ACQ || state_q == ST_EDGE2) ? (mode_q & ~dummy_q) :
                       (state_q == ST_CONV || state_q == ST_RDLO || state_q == ST_RDHI);
   assign adc_hben_o = (state_q == ST_RDHI);
endmodule

// File: rtl/sar_host_seq_chk.sv
module sar_host_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic busy_o,
   input logic asleep_o,
   input logic valid_o,
   input logic timeout_o,
   input logic adc_cs_n_o,
   input logic adc_rc_o,
   input logic adc_hben_o
);
   // R2
   cs_fall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!adc_cs_n_o && $past(adc_cs_n_o)) |-> busy_o);

   // R6
   hben_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adc_hben_o |-> (!adc_cs_n_o && adc_rc_o));

   // R9
   valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R9
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> !busy_o);

   // R5
   timeout_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> (!valid_o && !busy_o));

   // R7
   sleep_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(asleep_o) |-> (valid_o || timeout_o));
endmodule

bind sar_host_seq sar_host_seq_chk i_chk (
   .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .asleep_o(asleep_o),
   .valid_o(valid_o), .timeout_o(timeout_o), .adc_cs_n_o(adc_cs_n_o),
   .adc_rc_o(adc_rc_o), .adc_hben_o(adc_hben_o));

// File: tb/test_sar_host_seq.sv
`timescale 1ns/1ps
module test_sar_host_seq;
   localparam int ACQ    = 3;
   localparam int TMO    = 20;
   localparam int WAKE   = 10000;
   localparam int CDLY   = 9;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        shutdown_i = 1'b0;
   logic        busy_o, asleep_o, valid_o, timeout_o;
   logic [13:0] data_o;
   logic        adc_cs_n_o, adc_rc_o, adc_hben_o;
   logic        adc_eoc_n = 1'b1;
   logic [7:0]  adc_bus;

   always #4 clk = ~clk;

   sar_host_seq #(.CLK_KHZ(1000), .ACQ_CYC(ACQ), .CONV_TMO_CYC(TMO),
                  .WAKE_CYC(WAKE), .SETTLE_CYC(2)) i_sar_host_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .shutdown_i(shutdown_i),
      .busy_o(busy_o), .asleep_o(asleep_o), .data_o(data_o), .valid_o(valid_o),
      .timeout_o(timeout_o), .adc_cs_n_o(adc_cs_n_o), .adc_rc_o(adc_rc_o),
      .adc_hben_o(adc_hben_o), .adc_eoc_n_i(adc_eoc_n), .adc_bus_i(adc_bus));

   // converter model and monitor state
   int          cyc = 0, ph = 0, t1 = 0, ccnt = 0;
   int          nconv = 0, nstarts = 0, last_start_cyc = 0, nvalid = 0, ntmo = 0;
   int          mchecks = 0, merrs = 0;
   logic        prev_cs = 1'b1, prev_valid = 1'b0;
   logic        rc2_last = 1'b0, rc2_prev = 1'b0;
   logic [13:0] sample = '0;
   logic [1:0]  junk = '0;
   logic        hang_q = 1'b0;

   assign adc_bus = adc_hben_o ? {junk, sample[13:8]} : sample[7:0];

   always @(negedge clk) begin
      cyc <= cyc + 1;
      prev_cs <= adc_cs_n_o;
      prev_valid <= valid_o;
      if (valid_o) begin
         nvalid <= nvalid + 1;
         mchecks <= mchecks + 1;
         if (prev_valid) begin
            merrs <= merrs + 1;
            $display("FAIL R9 valid width: actual 2+ cycles expected 1");
         end
      end
      if (timeout_o) ntmo <= ntmo + 1;
      if (rst_n && prev_cs && !adc_cs_n_o) begin
         if (ph == 1) begin
            mchecks <= mchecks + 1;
            if (cyc - t1 != ACQ) begin
               merrs <= merrs + 1;
               $display("FAIL R3 acquisition window: actual %0d expected %0d", cyc - t1, ACQ);
            end
            rc2_prev <= rc2_last;
            rc2_last <= adc_rc_o;
            sample   <= 14'($urandom);
            junk     <= 2'($urandom);
            nconv    <= nconv + 1;
            ccnt     <= 0;
            ph       <= 2;
         end else if (!adc_rc_o) begin
            ph <= 1;
            t1 <= cyc;
            adc_eoc_n <= 1'b1;
            nstarts <= nstarts + 1;
            last_start_cyc <= cyc;
         end else if (ph == 3) begin
            mchecks <= mchecks + 1;
            if (adc_hben_o) begin
               merrs <= merrs + 1;
               $display("FAIL R6 read order: actual hben 1 expected 0 at first read edge");
            end
         end else begin
            merrs <= merrs + 1;
            $display("FAIL R3 cs fell with rc: actual 1 expected 0 (phase %0d)", ph);
         end
      end
      if (ph == 2) begin
         if (!hang_q) ccnt <= ccnt + 1;
         if (ccnt == CDLY) begin
            adc_eoc_n <= 1'b0;
            ph <= 3;
         end
      end
   end

   int checks = 0, errs = 0;
   logic exp_asleep = 1'b1;

   function automatic logic [13:0] exp_word(input logic [7:0] lo, input logic [7:0] hi);
      return {hi[5:0], lo};
   endfunction

   function automatic int exp_nconv(input logic sl);
      return sl ? 2 : 1;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic request(input logic mode, input logic hang, input logic poke);
      int n0, v0, t0, s0, ts, dts, g;
      logic sl;
      sl = exp_asleep;
      n0 = nconv; v0 = nvalid; t0 = ntmo; s0 = nstarts;
      hang_q = hang;
      @(negedge clk); #1;
      start_i = 1'b1; shutdown_i = mode; ts = cyc;
      @(negedge clk); #1;
      start_i = 1'b0;
      chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
      if (poke) begin
         repeat (3) @(negedge clk);
         #1; start_i = 1'b1; shutdown_i = !mode;
         @(negedge clk); #1; start_i = 1'b0;
      end
      g = 0;
      while (nstarts == s0 && g < 20000) begin
         @(negedge clk); #1; g++;
      end
      dts = last_start_cyc - ts;
      if (sl) chk(dts >= WAKE && dts <= WAKE + 4, "R8 wake wait", dts, WAKE);
      else    chk(dts <= 4, "R8 no wake wait", dts, 3);
      g = 0;
      while (busy_o && g < 20000) begin
         @(negedge clk); #1; g++;
      end
      repeat (2) @(negedge clk);
      #1;
      if (hang) begin
         chk(ntmo - t0 == 1, "R5 timeout pulse", ntmo - t0, 1);
         chk(nvalid == v0, "R5 no valid on timeout", nvalid - v0, 0);
         chk(asleep_o == 1'b1, "R5 asleep after timeout", asleep_o, 1);
         exp_asleep = 1'b1;
      end else begin
         chk(nconv - n0 == exp_nconv(sl), "R8 conversion count", nconv - n0, exp_nconv(sl));
         chk(nvalid - v0 == 1, "R9 one valid", nvalid - v0, 1);
         chk(rc2_last == mode, "R4 mode at hold edge", rc2_last, mode);
         if (poke) chk(rc2_last == mode, "R2 ignored start kept mode", rc2_last, mode);
         if (sl) chk(rc2_prev == 1'b0, "R4 dummy in standby", rc2_prev, 0);
         chk(data_o == exp_word(sample[7:0], {junk, sample[13:8]}), "R6 result word",
             data_o, exp_word(sample[7:0], {junk, sample[13:8]}));
         chk(asleep_o == mode, "R7 sleep flag", asleep_o, mode);
         exp_asleep = mode;
      end
      chk(ntmo - t0 == (hang ? 1 : 0), "R5 timeout count", ntmo - t0, hang ? 1 : 0);
      hang_q = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd1357));
      repeat (3) @(negedge clk);
      #1;
      chk(adc_cs_n_o == 1'b1, "R1 cs in reset", adc_cs_n_o, 1);
      chk(busy_o == 1'b0 && valid_o == 1'b0 && timeout_o == 1'b0, "R1 flags in reset",
          {busy_o, valid_o, timeout_o}, 0);
      chk(asleep_o == 1'b1, "R1 asleep in reset", asleep_o, 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      chk(asleep_o == 1'b1 && busy_o == 1'b0, "R1 after reset", {asleep_o, busy_o}, 2);
      request(1'b0, 1'b0, 1'b0);
      request(1'b0, 1'b0, 1'b1);
      request(1'b0, 1'b1, 1'b0);
      request(1'b0, 1'b0, 1'b0);
      request(1'b1, 1'b0, 1'b1);
      request(1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 8; i++) begin
         logic m, h;
         m = ($urandom % 3) == 0;
         h = !exp_asleep && (($urandom % 5) == 0);
         request(m, h, 1'($urandom));
      end
      repeat (4) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks + mchecks, errs + merrs);
      $finish;
   end

   initial begin
      #(8 * 190000);
      $display("FAIL watchdog: actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks + mchecks + 1, errs + merrs + 1);
      $finish;
   end
endmodule